// File: doc/BRIEF.md
# Flash Command Unlock Decoder

This block sits behind the bus interface of a parallel NOR flash and watches every write cycle the host issues. Alterations of the array are guarded by fixed address/data unlock patterns. The decoder walks through those patterns one write at a time. When a pattern is complete, it raises a one-cycle start pulse that carries the operation kind, the target address and the final data byte, so that the array controller can begin the internal work.

It also keeps two read-mode flags, one for the identification read mode and one for the query-table read mode. The read path uses these flags to choose what a read returns. While the array controller reports an internal program or erase in progress, the decoder ignores every write, and that includes the exit command.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `start` is 0, `op` is 0, and both `id_mode` and `cfi_mode` are 0.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any fourth write, give `start`=1 with `op`=1 (program). `op_addr` and `op_data` equal the fourth write. The pulse appears in the cycle after the fourth write is sampled.
- R3: The erase prefix is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. A sixth write of 10h@5555h then gives `start` with `op`=4 (chip erase) and `op_addr`=0.
- R4: The erase prefix followed by 30h at any address gives `op`=2 (sector erase), and `op_addr` is that address with bits 10:0 cleared.
- R5: The erase prefix followed by 50h at any address gives `op`=3 (block erase), and `op_addr` is that address with bits 14:0 cleared.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode` to 1 and clears `cfi_mode`.
- R7: AAh@5555h, 55h@2AAAh, 98h@5555h sets `cfi_mode` to 1 and clears `id_mode`.
- R8: A single F0h write at any address, made when no sequence is under way, clears both mode flags. The three-write form ending in F0h@5555h clears them as well.
- R9: A write that breaks the expected pattern returns the decoder to the start of a sequence with no pulse. The mode flags keep their values, and a later sequence must begin again from AAh@5555h.
- R10: While `busy` is 1, writes have no effect: no pulse, no mode change, and the position within a partly entered sequence is kept.
- R11: Only address bits 14:0 are compared against the unlock addresses. Higher address bits may take any value.
- R12: `start` is high for exactly one cycle per completed sequence. Whenever `start` is 0, `op` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle marker of a captured bus write |
| wr_addr | input | AW | Captured write address |
| wr_data | input | 8 | Captured low data byte |
| busy | input | 1 | Internal program or erase in progress |
| start | output | 1 | One-cycle operation start pulse |
| op | output | 3 | Operation: 1 program, 2 sector erase, 3 block erase, 4 chip erase, 0 none |
| op_addr | output | AW | Target address, aligned for erases |
| op_data | output | 8 | Data byte of the final write |
| id_mode | output | 1 | Identification read mode active |
| cfi_mode | output | 1 | Query-table read mode active |

## Verification
The assertions assume that `wr_valid` lasts one cycle per bus write. They also assume that `busy` is driven by the downstream controller and is not tied to the decoder's own state. The bench keeps to these assumptions: each write task raises `wr_valid` for a single cycle and lowers it for at least one cycle. `busy` is changed only between writes. This is what lets the stability checks on the mode flags under `busy` stand on their own.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy,
  output logic          start,
  output logic [2:0]    op,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          id_mode,
  output logic          cfi_mode
);
  localparam logic [14:0] UNL_A = 15'h5555;
  localparam logic [14:0] UNL_B = 15'h2AAA;
  localparam logic [2:0]  OP_PROG = 3'd1;
  localparam logic [2:0]  OP_SECT = 3'd2;
  localparam logic [2:0]  OP_BLK  = 3'd3;
  localparam logic [2:0]  OP_CHIP = 3'd4;
  localparam int SECT_LSB = 11;
  localparam int BLK_LSB  = 15;

  typedef enum logic [2:0] {ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E3, ST_E4, ST_E5} st_t;

  st_t st, st_nx;
  logic go, id_nx, cfi_nx;
  logic [2:0] op_nx;
  logic [AW-1:0] addr_nx;

  wire take  = wr_valid && !busy;
  wire hit_a = wr_addr[14:0] == UNL_A;
  wire hit_b = wr_addr[14:0] == UNL_B;
  wire [AW-1:0] sect_addr = {wr_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
  wire [AW-1:0] blk_addr  = {wr_addr[AW-1:BLK_LSB], {BLK_LSB{1'b0}}};

  always_comb begin
    st_nx   = st;
    go      = 1'b0;
    op_nx   = '0;
    addr_nx = wr_addr;
    id_nx   = id_mode;
    cfi_nx  = cfi_mode;
    if (take) begin
      st_nx = ST_IDLE;
      case (st)
        ST_IDLE: begin
          if (hit_a && wr_data == 8'hAA) st_nx = ST_U1;
          else if (wr_data == 8'hF0) begin id_nx = 1'b0; cfi_nx = 1'b0; end
        end
        ST_U1: if (hit_b && wr_data == 8'h55) st_nx = ST_U2;
        ST_U2: if (hit_a) begin
          case (wr_data)
            8'hA0: st_nx = ST_PGM;
            8'h80: st_nx = ST_E3;
            8'h90: begin id_nx = 1'b1; cfi_nx = 1'b0; end
            8'h98: begin id_nx = 1'b0; cfi_nx = 1'b1; end
            8'hF0: begin id_nx = 1'b0; cfi_nx = 1'b0; end
            default: ;
          endcase
        end
        ST_PGM: begin go = 1'b1; op_nx = OP_PROG; end
        ST_E3: if (hit_a && wr_data == 8'hAA) st_nx = ST_E4;
        ST_E4: if (hit_b && wr_data == 8'h55) st_nx = ST_E5;
        ST_E5: begin
          if (wr_data == 8'h10 && hit_a) begin go = 1'b1; op_nx = OP_CHIP; addr_nx = '0; end
          else if (wr_data == 8'h30) begin go = 1'b1; op_nx = OP_SECT; addr_nx = sect_addr; end
          else if (wr_data == 8'h50) begin go = 1'b1; op_nx = OP_BLK; addr_nx = blk_addr; end
        end
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      start    <= 1'b0;
      op       <= '0;
      op_addr  <= '0;
      op_data  <= '0;
      id_mode  <= 1'b0;
      cfi_mode <= 1'b0;
    end else begin
      st       <= st_nx;
      start    <= go;
      op       <= go ? op_nx : 3'd0;
      id_mode  <= id_nx;
      cfi_mode <= cfi_nx;
      if (go) begin
        op_addr <= addr_nx;
        op_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          busy,
  input logic          start,
  input logic [2:0]    op,
  input logic [AW-1:0] op_addr,
  input logic          id_mode,
  input logic          cfi_mode
);
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  p_op_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> op == 3'd0);
  p_op_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (op >= 3'd1 && op <= 3'd4));
  p_no_write_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !start);
  p_busy_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !start);
  p_busy_modes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(id_mode) && $stable(cfi_mode)));
  p_modes_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_mode && cfi_mode));
  p_sect_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd2) |-> op_addr[10:0] == 11'd0);
  p_blk_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd3) |-> op_addr[14:0] == 15'd0);
  p_chip_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd4) |-> op_addr == '0);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .busy(busy),
  .start(start), .op(op), .op_addr(op_addr),
  .id_mode(id_mode), .cfi_mode(cfi_mode)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int AW = 19;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy = 1'b0;
  logic start;
  logic [2:0] op;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;
  logic id_mode, cfi_mode;
  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .start(start), .op(op), .op_addr(op_addr),
    .op_data(op_data), .id_mode(id_mode), .cfi_mode(cfi_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, cmd);
  endtask

  task automatic erase5();
    unlock3(8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask

  task automatic t_reset();
    chk("R1 start", start, 0); chk("R1 op", op, 0);
    chk("R1 id_mode", id_mode, 0); chk("R1 cfi_mode", cfi_mode, 0);
  endtask

  task automatic t_program();
    unlock3(8'hA0);
    chk("R2 no early start", start, 0);
    wr(19'h3_1234, 8'h5A);
    chk("R2 start", start, 1); chk("R2 op", op, 1);
    chk("R2 addr", op_addr, 19'h3_1234); chk("R2 data", op_data, 8'h5A);
    @(negedge clk);
    chk("R12 pulse width", start, 0); chk("R12 op idle", op, 0);
  endtask

  task automatic t_chip();
    erase5(); wr(19'h05555, 8'h10);
    chk("R3 start", start, 1); chk("R3 op", op, 4); chk("R3 addr", op_addr, 0);
  endtask

  task automatic t_sector();
    erase5(); wr(19'h5_3ABC, 8'h30);
    chk("R4 start", start, 1); chk("R4 op", op, 2); chk("R4 addr", op_addr, 19'h5_3800);
  endtask

  task automatic t_block();
    erase5(); wr(19'h6_F123, 8'h50);
    chk("R5 start", start, 1); chk("R5 op", op, 3); chk("R5 addr", op_addr, 19'h6_8000);
  endtask

  task automatic t_modes();
    unlock3(8'h90);
    chk("R6 id", id_mode, 1); chk("R6 cfi", cfi_mode, 0);
    unlock3(8'h98);
    chk("R7 cfi", cfi_mode, 1); chk("R7 id", id_mode, 0);
    wr(19'h0_0123, 8'hF0);
    chk("R8 single exit cfi", cfi_mode, 0);
    unlock3(8'h90);
    unlock3(8'hF0);
    chk("R8 three-write exit", id_mode, 0);
  endtask

  task automatic t_abort();
    unlock3(8'h90);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05554, 8'hA0);
    wr(19'h0_0400, 8'h11);
    chk("R9 bad addr no start", start, 0);
    chk("R9 mode kept", id_mode, 1);
    wr(19'h05555, 8'hAA); wr(19'h05555, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h0_0400, 8'h22);
    chk("R9 bad data no start", start, 0);
    erase5(); wr(19'h05555, 8'h77); wr(19'h05555, 8'h10);
    chk("R9 bad erase code", start, 0);
    wr(19'h0_0000, 8'hF0);
  endtask

  task automatic t_busy();
    unlock3(8'h90);
    busy = 1'b1;
    wr(19'h0_0000, 8'hF0);
    chk("R10 exit ignored", id_mode, 1);
    busy = 1'b0;
    wr(19'h0_0000, 8'hF0);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    busy = 1'b1;
    wr(19'h05555, 8'hA0); wr(19'h0_0042, 8'h33);
    chk("R10 no start while busy", start, 0);
    busy = 1'b0;
    wr(19'h05555, 8'hA0); wr(19'h0_0042, 8'h44);
    chk("R10 position kept", start, 1); chk("R10 data", op_data, 8'h44);
  endtask

  task automatic t_high_bits();
    wr(19'h7_5555, 8'hAA); wr(19'h4_2AAA, 8'h55); wr(19'h2_D555, 8'hA0);
    wr(19'h0_0007, 8'h99);
    chk("R11 high bits ignored", start, 1); chk("R11 op", op, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_program(); t_chip(); t_sector(); t_block();
    t_modes(); t_abort(); t_busy(); t_high_bits();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule